// File: doc/BRIEF.md
# SPI Device-Side Memory Access Bridge

This block sits on the device side of a serial link and lets an external SPI controller read and write a 32-bit, byte-addressed, little-endian memory. Each frame opens with a command byte that selects direction and transfer size, followed by a four-byte start address. Write frames then carry data words and close with one extra pad byte. Read frames carry four idle bytes while the memory is fetched, and then the device returns data words on MISO.

Words on the wire are 2, 4 or 8 bytes long according to the command, and each is sent most significant byte first. The bridge treats each word as an integer. It stores that integer in little-endian byte order on a 64-bit memory port with byte enables, and it rebuilds the integer from that port when reading. The wire byte order is therefore the reverse of the memory byte order within every word. Burst commands move any number of 8-byte words and step the address by 8 after each word, until chip select is released.

The serial inputs are not clocked by the system clock. They pass through a two-flop synchroniser, and the bridge samples MOSI on the synchronised rising edge of SCLK (SPI mode 0). The memory port is a simple synchronous one: a single-cycle write strobe with byte enables, and a single-cycle read strobe whose data returns on the next cycle.

Top module: `spi_mem_bridge`

## Requirements
- R1: While reset is applied or chip select is high, `spi_miso`, `mem_we` and `mem_re` are all low.
- R2: The command byte selects the operation. 0x00 is read 16-bit, 0x01 is write 16-bit, 0x02 is read 32-bit, 0x03 is write 32-bit, 0x04 is read burst and 0x05 is write burst. Bit 0 set means write. Bits 2:1 give the word size: 0 means 2 bytes, 1 means 4 bytes, 2 means 8 bytes.
- R3: The four bytes after the command form the 32-bit start address, most significant byte first. `mem_addr` presents the full byte address of each word it accesses.
- R4: A written word of N bytes, with wire bytes k = 0..N-1, lands in memory little-endian. Let L = `mem_addr[2:0]`. Then `mem_be` bits L..L+N-1 are set, and `mem_wdata` byte lane L+N-1-k holds wire byte k.
- R5: Each complete data word of a write frame produces exactly one single-cycle `mem_we` pulse. The trailing pad byte, and any other incomplete word, is never written.
- R6: In 16-bit and 32-bit write frames, bytes after the first complete word are ignored.
- R7: A read frame fetches its first word once the header is complete. `spi_miso` stays low during the four idle bytes that follow the address. The word is then shifted out MSB first: wire byte k equals the memory byte at address A+N-1-k. `spi_miso` moves to the next bit just after each sampled SCLK rising edge.
- R8: In a burst, the address of each word is 8 more than the previous one, for both reads and writes, until chip select rises. Frames of 30 words (240 bytes) are supported.
- R9: In 16-bit and 32-bit read frames, `spi_miso` is low after the single data word.
- R10: A command byte from 0x06 to 0xFF causes no memory strobe, and `spi_miso` stays low until chip select rises.
- R11: Raising chip select in the middle of a frame drops any partial word. The next frame starts again at the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the controller, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| mem_addr | output | 32 | Byte address of the current memory access |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_be | output | 8 | Byte-lane enables for a write |
| mem_wdata | output | 64 | Write data, lane-aligned |
| mem_re | output | 1 | Single-cycle read strobe |
| mem_rdata | input | 64 | Read data, valid the cycle after `mem_re` |

## Verification
The assertions take four things for granted about the inputs:
- every start address is naturally aligned to its word size, so a word never crosses the 8-byte bus;
- each SCLK level lasts several system clocks;
- chip select only changes while SCLK is low;
- read data arrives one cycle after the strobe.

The stimulus respects all four. It uses aligned addresses only, holds each SCLK level for eight system clocks, and toggles chip select with SCLK idle. It also models a memory with a one-cycle read latency.

// File: rtl/spib_pkg.sv
// Shared constants, types and helpers for the SPI memory bridge.
// Assumes a fixed 32-bit address header and an 8-byte memory bus.
package spib_pkg;
    localparam int ADDR_W         = 32;
    localparam int WORD_BYTES     = 8;
    localparam int BUS_W          = 8 * WORD_BYTES;
    localparam int HDR_ADDR_BYTES = ADDR_W / 8;
    localparam int RD_IDLE_BYTES  = 4;
    localparam int HCNT_W         = $clog2(HDR_ADDR_BYTES);
    localparam logic [7:0] LAST_CMD = 8'h05;

    // Access size, encoded exactly as command bits 2:1
    typedef enum logic [1:0] {
        SZ_HALF  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_BURST = 2'd2,
        SZ_NONE  = 2'd3
    } size_e;

    // Frame phase of the serial engine
    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_IDLE,
        PH_DATA,
        PH_SKIP
    } phase_e;

    // Byte count of one data word for a given size
    function automatic logic [3:0] size_bytes(size_e s);
        case (s)
            SZ_HALF: return 4'd2;
            SZ_WORD: return 4'd4;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/spib_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each input bit is independent, or stable around its siblings' edges.
module spib_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw asynchronous inputs
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= d_in;
            end
        end else begin : g_next
            // Later stages resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/spib_lanes.sv
// Steers a right-justified word value to and from the byte lanes of the bus.
// Assumes the lane offset plus the word size never exceeds the bus width.
module spib_lanes
    import spib_pkg::*;
(
    input  logic [2:0]       lane,
    input  size_e            size,
    input  logic [BUS_W-1:0] wr_value,
    input  logic [BUS_W-1:0] rd_bus,
    output logic [BUS_W-1:0] wr_bus,
    output logic [7:0]       wr_be,
    output logic [BUS_W-1:0] rd_value
);
    logic [3:0]       nb;
    logic [BUS_W-1:0] byte_mask;
    logic [5:0]       shamt;

    // Derive the live-byte mask and the lane shift amount
    always_comb begin
        nb        = size_bytes(size);
        byte_mask = (nb == 4'(WORD_BYTES)) ? '1
                                           : ((BUS_W'(1) << {nb, 3'b000}) - BUS_W'(1));
        shamt     = {lane, 3'b000};
    end

    assign wr_bus   = (wr_value & byte_mask) << shamt;
    assign rd_value = (rd_bus >> shamt) & byte_mask;

    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_be
        assign wr_be[i] = (4'(i) >= {1'b0, lane}) && (4'(i) < ({1'b0, lane} + nb));
    end
endmodule

// File: rtl/spib_engine.sv
// Serial frame engine. It counts bits and bytes, decodes the header,
// packs write words, prefetches read words and shifts MISO.
// Assumes synchronised inputs, with each SCLK level lasting at least three clk
// cycles, and memory read data one cycle after mem_re.
module spib_engine
    import spib_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              cs_act,
    input  logic [BUS_W-1:0]  rd_value,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BUS_W-1:0]  wr_value,
    output size_e             acc_size,
    output logic              miso
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic              sclk_q;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sr;
    phase_e            phase;
    logic [HCNT_W-1:0] bcnt;
    logic              is_wr;
    size_e             size;
    logic [ADDR_W-1:0] cur_addr;
    logic [2:0]        wbytes;
    logic [BUS_W-9:0]  wacc;
    logic [BUS_W-1:0]  tx_sr;
    logic [5:0]        tx_cnt;
    logic              rd_pend;
    logic [BUS_W-1:0]  rd_hold;

    logic              rise;
    logic              byte_done;
    logic [7:0]        rx_byte;
    logic [BUS_W-1:0]  wacc_nx;
    logic [ADDR_W-1:0] hdr_addr;
    logic [3:0]        nb;
    logic [6:0]        nbits;
    logic [2:0]        last_byte;
    logic [5:0]        last_bit;
    logic [BUS_W-1:0]  load_word;

    // Derive edge and byte events, plus per-size word limits
    always_comb begin
        rise      = cs_act && sclk_s && !sclk_q;
        byte_done = rise && (bit_cnt == 3'd7);
        rx_byte   = {rx_sr, mosi_s};
        wacc_nx   = {wacc, rx_byte};
        hdr_addr  = {cur_addr[ADDR_W-9:0], rx_byte};
        nb        = size_bytes(size);
        nbits     = {nb, 3'b000};
        last_byte = 3'(nb - 4'd1);
        last_bit  = 6'(nbits - 7'd1);
        load_word = rd_hold << (7'(BUS_W) - nbits);
    end

    // Remember the previous synchronised SCLK level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Shift MOSI in on each sampled rising edge and count bits in the byte
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sr   <= {rx_sr[5:0], mosi_s};
        end
    end

    // Frame sequencing, memory strobes and MISO shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_CMD;
            bcnt     <= '0;
            is_wr    <= 1'b0;
            size     <= SZ_HALF;
            cur_addr <= '0;
            wbytes   <= '0;
            wacc     <= '0;
            tx_sr    <= '0;
            tx_cnt   <= '0;
            mem_we   <= 1'b0;
            mem_re   <= 1'b0;
            mem_addr <= '0;
            wr_value <= '0;
            acc_size <= SZ_HALF;
        end else begin
            mem_we <= 1'b0;
            mem_re <= 1'b0;
            if (!cs_act) begin
                phase  <= PH_CMD;
                bcnt   <= '0;
                wbytes <= '0;
                tx_sr  <= '0;
                tx_cnt <= '0;
            end else begin
                case (phase)
                    PH_CMD: if (byte_done) begin
                        if (rx_byte <= LAST_CMD) begin
                            is_wr <= rx_byte[0];
                            size  <= size_e'(rx_byte[2:1]);
                            phase <= PH_ADDR;
                            bcnt  <= '0;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_ADDR: if (byte_done) begin
                        cur_addr <= hdr_addr;
                        bcnt     <= bcnt + 1'b1;
                        if (bcnt == HCNT_W'(HDR_ADDR_BYTES - 1)) begin
                            bcnt   <= '0;
                            wbytes <= '0;
                            if (is_wr) begin
                                phase <= PH_DATA;
                            end else begin
                                phase    <= PH_IDLE;
                                mem_re   <= 1'b1;
                                mem_addr <= hdr_addr;
                                acc_size <= size;
                            end
                        end
                    end
                    PH_IDLE: if (byte_done) begin
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == HCNT_W'(RD_IDLE_BYTES - 1)) begin
                            phase  <= PH_DATA;
                            tx_sr  <= load_word;
                            tx_cnt <= '0;
                            if (size == SZ_BURST) begin
                                mem_re   <= 1'b1;
                                mem_addr <= cur_addr + STEP;
                                cur_addr <= cur_addr + STEP;
                            end
                        end
                    end
                    PH_DATA: begin
                        if (is_wr) begin
                            if (byte_done) begin
                                wacc   <= wacc_nx[BUS_W-9:0];
                                wbytes <= wbytes + 3'd1;
                                if (wbytes == last_byte) begin
                                    mem_we   <= 1'b1;
                                    mem_addr <= cur_addr;
                                    wr_value <= wacc_nx;
                                    acc_size <= size;
                                    wbytes   <= '0;
                                    if (size == SZ_BURST) cur_addr <= cur_addr + STEP;
                                    else                  phase    <= PH_SKIP;
                                end
                            end
                        end else if (rise) begin
                            tx_cnt <= tx_cnt + 6'd1;
                            tx_sr  <= tx_sr << 1;
                            if (tx_cnt == last_bit) begin
                                tx_cnt <= '0;
                                if (size == SZ_BURST) begin
                                    tx_sr    <= load_word;
                                    mem_re   <= 1'b1;
                                    mem_addr <= cur_addr + STEP;
                                    cur_addr <= cur_addr + STEP;
                                end else begin
                                    tx_sr <= '0;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Capture the lane-extracted read word one cycle after each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_hold <= '0;
        end else begin
            rd_pend <= mem_re;
            if (rd_pend) rd_hold <= rd_value;
        end
    end

    assign miso = tx_sr[BUS_W-1];

    // R1: one cycle after chip select goes inactive, no strobe is active
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!mem_we && !mem_re));

    // R5: a write and a read never share a cycle
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R5: each write strobe lasts a single cycle
    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7: the four idle bytes of a read keep MISO low
    p_idle_miso_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !miso);

    // R10: an ignored frame issues no read and drives MISO low
    p_skip_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> (!mem_re && !miso));

    // R4: the start address of every written word is aligned to its size
    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr[2:0] & 3'(size_bytes(acc_size) - 4'd1)) == 3'd0));
endmodule

// File: rtl/spi_mem_bridge.sv
// Top level of the SPI memory bridge. It synchronises the serial pins,
// runs the frame engine and steers words onto the 64-bit memory bus.
// Assumes SPI mode 0 and a memory that returns read data one cycle after mem_re.
module spi_mem_bridge
    import spib_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_be,
    output logic [BUS_W-1:0]  mem_wdata,
    output logic              mem_re,
    input  logic [BUS_W-1:0]  mem_rdata
);
    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] eng_addr;
    logic [BUS_W-1:0]  wr_value;
    logic [BUS_W-1:0]  rd_value;
    size_e             acc_size;

    spib_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({spi_cs_n, spi_sclk, spi_mosi}),
        .d_out (pins_s)
    );

    spib_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .cs_act   (!pins_s[2]),
        .rd_value (rd_value),
        .mem_addr (eng_addr),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .wr_value (wr_value),
        .acc_size (acc_size),
        .miso     (spi_miso)
    );

    spib_lanes u_lanes (
        .lane     (eng_addr[2:0]),
        .size     (acc_size),
        .wr_value (wr_value),
        .rd_bus   (mem_rdata),
        .wr_bus   (mem_wdata),
        .wr_be    (mem_be),
        .rd_value (rd_value)
    );

    assign mem_addr = eng_addr;
endmodule

// File: tb/spi_mem_bridge_test.sv
// Scoreboard bench: the frame driver queues the expected memory writes and
// a monitor checks them as they appear. Read data is checked against a
// reference byte image that the bench keeps itself.
module spi_mem_bridge_test;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [31:0] mem_addr;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;

    always #10 clk = ~clk;

    spi_mem_bridge uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (sclk),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [7:0]  be;
        logic [63:0] d;
    } wr_item_t;

    wr_item_t    wr_q[$];
    logic [7:0]  mem_b [0:511];
    logic [7:0]  ref_b [0:511];
    logic [7:0]  tx_b  [0:299];
    logic [7:0]  rx_b  [0:299];
    int          n_chk = 0;
    int          n_bad = 0;
    int          re_cnt = 0;
    int          we_cnt = 0;
    bit          done = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: byte-lane writes, registered reads
    always @(posedge clk) begin
        if (mem_we)
            for (int j = 0; j < 8; j++)
                if (mem_be[j]) mem_b[{mem_addr[8:3], 3'(j)}] <= mem_wdata[8*j +: 8];
        if (mem_re)
            for (int j = 0; j < 8; j++)
                mem_rdata[8*j +: 8] <= mem_b[{mem_addr[8:3], 3'(j)}];
    end

    // Monitor: compare each write strobe with the head of the expected queue
    always @(negedge clk) begin
        wr_item_t e;
        logic     ok_d;
        if (rst_n) begin
            if (mem_re) re_cnt++;
            if (mem_we) begin
                we_cnt++;
                if (wr_q.size() == 0) begin
                    check(1'b0, "R5 unexpected write", 64'(mem_addr), 64'hx);
                end else begin
                    e = wr_q.pop_front();
                    check(mem_addr == e.a, "R3 write address", 64'(mem_addr), 64'(e.a));
                    check(mem_be == e.be, "R4 byte enables", 64'(mem_be), 64'(e.be));
                    ok_d = 1'b1;
                    for (int j = 0; j < 8; j++)
                        if (e.be[j] && mem_wdata[8*j +: 8] != e.d[8*j +: 8]) ok_d = 1'b0;
                    check(ok_d, "R4 write data lanes", mem_wdata, e.d);
                end
            end
        end
    end

    task automatic put_hdr(input logic [7:0] cmd, input logic [31:0] a);
        tx_b[0] = cmd;
        for (int i = 0; i < 4; i++) tx_b[1+i] = a[31-8*i -: 8];
    endtask

    // Queue one expected write and update the reference image (little-endian)
    task automatic push_wr(input logic [31:0] a, input int n, input int idx);
        wr_item_t it;
        it.a  = a;
        it.be = '0;
        it.d  = '0;
        for (int k = 0; k < n; k++) begin
            int lane = int'(a[2:0]) + n - 1 - k;
            it.be[lane]        = 1'b1;
            it.d[8*lane +: 8]  = tx_b[idx+k];
            ref_b[int'(a[8:0]) + n - 1 - k] = tx_b[idx+k];
        end
        wr_q.push_back(it);
    endtask

    task automatic spi_xfer(input int n);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                mosi = tx_b[i][b];
                repeat (HALF) @(negedge clk);
                rx_b[i][b] = miso;
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic expect_read(input logic [31:0] a, input int n, input int words, input int base, input string req);
        for (int w = 0; w < words; w++) begin
            for (int k = 0; k < n; k++) begin
                int off = int'(a[8:0]) + 8*w + n - 1 - k;
                check(rx_b[base + w*n + k] == ref_b[off], req, 64'(rx_b[base + w*n + k]), 64'(ref_b[off]));
            end
        end
    endtask

    task automatic expect_zero(input int base, input int cnt, input string req);
        logic [7:0] acc;
        acc = '0;
        for (int i = 0; i < cnt; i++) acc = acc | rx_b[base+i];
        check(acc == 8'h00, req, 64'(acc), 64'h0);
    endtask

    task automatic expect_drained(input string req);
        check(wr_q.size() == 0, req, 64'(wr_q.size()), 64'h0);
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 64'h0, 64'h1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int re0;
        int we0;
        for (int i = 0; i < 512; i++) begin
            mem_b[i] = 8'(i*37 + 11);
            ref_b[i] = 8'(i*37 + 11);
        end
        repeat (5) @(negedge clk);
        // R1: outputs quiet during reset
        check(miso == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1 reset state",
              64'({miso, mem_we, mem_re}), 64'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(miso == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1 idle with CS high",
              64'({miso, mem_we, mem_re}), 64'h0);

        // R2 R4 R5: 16-bit write with trailing pad byte
        put_hdr(8'h01, 32'h2A00_0102);
        tx_b[5] = 8'hAB; tx_b[6] = 8'hCD; tx_b[7] = 8'h5A;
        push_wr(32'h2A00_0102, 2, 5);
        spi_xfer(8);
        expect_drained("R5 16-bit write count");

        // R2 R4: 32-bit write
        put_hdr(8'h03, 32'h2A00_0104);
        tx_b[5] = 8'h11; tx_b[6] = 8'h22; tx_b[7] = 8'h33; tx_b[8] = 8'h44; tx_b[9] = 8'hE7;
        push_wr(32'h2A00_0104, 4, 5);
        spi_xfer(10);
        expect_drained("R5 32-bit write count");

        // R8: burst write of three words
        put_hdr(8'h05, 32'h2A00_0110);
        for (int i = 0; i < 24; i++) tx_b[5+i] = 8'(8'hC0 + i*3);
        tx_b[29] = 8'h99;
        for (int w = 0; w < 3; w++) push_wr(32'h2A00_0110 + 32'(8*w), 8, 5 + 8*w);
        spi_xfer(30);
        expect_drained("R8 burst write count");

        // R6: a 16-bit write followed by extra bytes writes only the first word
        put_hdr(8'h01, 32'h2A00_0106);
        tx_b[5] = 8'h6E; tx_b[6] = 8'h7F;
        for (int i = 0; i < 5; i++) tx_b[7+i] = 8'hF0 + 8'(i);
        push_wr(32'h2A00_0106, 2, 5);
        spi_xfer(12);
        expect_drained("R6 extra bytes ignored");

        // R7 R9: 16-bit read, then idle bytes and trailing bytes must be low
        put_hdr(8'h00, 32'h2A00_0102);
        for (int i = 5; i < 13; i++) tx_b[i] = 8'hFF;
        spi_xfer(13);
        expect_zero(5, 4, "R7 idle bytes low (16-bit read)");
        expect_read(32'h2A00_0102, 2, 1, 9, "R7 16-bit read data");
        expect_zero(11, 2, "R9 MISO low after 16-bit word");

        // R7 R9: 32-bit read
        put_hdr(8'h02, 32'h2A00_0104);
        for (int i = 5; i < 15; i++) tx_b[i] = 8'h00;
        spi_xfer(15);
        expect_zero(5, 4, "R7 idle bytes low (32-bit read)");
        expect_read(32'h2A00_0104, 4, 1, 9, "R7 32-bit read data");
        expect_zero(13, 2, "R9 MISO low after 32-bit word");

        // R8: burst read of four words across written and untouched bytes
        put_hdr(8'h04, 32'h2A00_0108);
        for (int i = 5; i < 41; i++) tx_b[i] = 8'h00;
        spi_xfer(41);
        expect_read(32'h2A00_0108, 8, 4, 9, "R8 burst read data");

        // R10: undefined command is ignored
        re0 = re_cnt;
        we0 = we_cnt;
        put_hdr(8'h07, 32'h2A00_0100);
        for (int i = 5; i < 17; i++) tx_b[i] = 8'hA5;
        spi_xfer(17);
        check(re_cnt == re0 && we_cnt == we0, "R10 no strobes on undefined command",
              64'(re_cnt - re0 + we_cnt - we0), 64'h0);
        expect_zero(0, 17, "R10 MISO low on undefined command");

        // R11: chip select released in mid-word drops the partial word
        we0 = we_cnt;
        put_hdr(8'h03, 32'h2A00_0140);
        tx_b[5] = 8'h12; tx_b[6] = 8'h34;
        spi_xfer(7);
        check(we_cnt == we0, "R11 partial word not written", 64'(we_cnt - we0), 64'h0);
        put_hdr(8'h01, 32'h2A00_0140);
        tx_b[5] = 8'h5C; tx_b[6] = 8'h3D; tx_b[7] = 8'h00;
        push_wr(32'h2A00_0140, 2, 5);
        spi_xfer(8);
        expect_drained("R11 next frame decoded afresh");

        // R8: 240-byte burst write, then read back the last word and the one after it
        put_hdr(8'h05, 32'h2A00_0000);
        for (int i = 0; i < 240; i++) tx_b[5+i] = 8'(i*11 + 3);
        tx_b[245] = 8'h77;
        for (int w = 0; w < 30; w++) push_wr(32'h2A00_0000 + 32'(8*w), 8, 5 + 8*w);
        spi_xfer(246);
        expect_drained("R8 240-byte burst write count");
        put_hdr(8'h04, 32'h2A00_00E8);
        for (int i = 5; i < 25; i++) tx_b[i] = 8'h00;
        spi_xfer(25);
        expect_read(32'h2A00_00E8, 8, 2, 9, "R8 burst read after long write");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule